// File: doc/BRIEF.md
# Convergent Rounding Width Reducer

This block narrows a signed two's-complement sample from `IN_W` bits to `OUT_W` bits by discarding its `IN_W-OUT_W` least significant bits. It rounds to the nearest representable value. A value that falls exactly halfway between two neighbours goes to the neighbour whose least significant bit is zero (round-half-to-even), so rounding over many samples carries no DC bias. It sits in datapaths such as filter outputs or accumulator read-outs, where a wide intermediate result must be cut to a bus width.

A sample and its qualifier are presented on one cycle, and the rounded sample comes out on the next clock edge. When the two widths are equal the sample passes straight through. When only one bit is discarded, a simplified form of the same rule applies. By default a positive result that rounds beyond the output range wraps around. Setting `SATURATE` makes such a result clamp to the largest positive code instead.

Top module: `cvg_round_reducer`

## Requirements
- R1: With `IN_W == OUT_W`, `out_data` equals the registered `in_data` bit for bit.
- R2: With `IN_W == OUT_W+1`, the result is `in_data` arithmetically shifted right by one, plus one exactly when `in_data[1]` and `in_data[0]` are both 1.
- R3: With two or more bits discarded, the truncated value is `in_data[IN_W-1:IN_W-OUT_W]`. When the highest discarded bit (the half bit) is 0, the result is that truncated value.
- R4: With two or more bits discarded, when the half bit is 1 and any lower discarded bit is 1, the result is the truncated value plus one.
- R5: With two or more bits discarded, when the discarded bits equal exactly one half (half bit 1, all lower bits 0), the result is the truncated value plus one if its bit 0 is 1, and the truncated value unchanged otherwise.
- R6: Negative inputs follow the same bit-pattern rules. For example, -0.5 rounds to 0, -1.5 rounds to -2 and -2.5 rounds to -2.
- R7: With `SATURATE = 0` (the default), a result beyond the largest positive code wraps modulo 2^`OUT_W`. For example, 16-bit 0x7FFF reduced to 8 bits gives 0x80.
- R8: With `SATURATE = 1`, a non-negative input never yields a negative output. A result that would exceed the largest positive code gives 0x7F (for `OUT_W` = 8).
- R9: `out_valid` equals `in_valid` of the previous cycle. `out_data` takes the new result only in a cycle after `in_valid` was 1, and otherwise holds its value.
- R10: While `rst_n` is 0 at a rising edge, `out_valid` and `out_data` are cleared to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` this cycle |
| in_data | input | IN_W | Signed wide sample |
| out_valid | output | 1 | Qualifies `out_data`, one cycle after `in_valid` |
| out_data | output | OUT_W | Signed rounded sample |

## Verification
The bound checker watches the latency and hold behaviour of the valid/data pair, and the reset clear, on every cycle. For the configuration in use, it also checks the result against the wide input whenever the input is decided without a tie (half bit clear, or half bit set with a nonzero remainder), and in the even-tie case. The saturating variant is checked for never turning a non-negative input negative. What only the bench can show is the rest: the odd-tie step to the even neighbour, exact negative tie values, the wrap-around code at the top of the range, and the equal-width and single-bit variants, which the bench covers with separate instances on known vectors.

// File: rtl/cvg_round_pkg.sv
// Shared types for the convergent rounding reducer.
// Assumes callers pass a non-negative bit-drop count.
package cvg_round_pkg;

    typedef enum logic [1:0] {
        DROP_NONE  = 2'd0,
        DROP_SINGLE = 2'd1,
        DROP_MULTI = 2'd2
    } drop_kind_e;

    // Classify how many low bits are discarded.
    function automatic drop_kind_e drop_kind(input int drop_bits);
        if (drop_bits <= 0)
            return DROP_NONE;
        else if (drop_bits == 1)
            return DROP_SINGLE;
        else
            return DROP_MULTI;
    endfunction

endpackage

// File: rtl/cvg_round_split.sv
// Splits a wide signed sample into its truncated upper part, the half
// bit (highest discarded bit) and a sticky OR of the discarded bits below it.
// Assumes IN_W >= OUT_W >= 2. Purely combinational.
module cvg_round_split
    import cvg_round_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  wide_i,
    output logic [OUT_W-1:0] trunc_o,
    output logic             half_o,
    output logic             sticky_o
);
    localparam int         DROP = IN_W - OUT_W;
    localparam drop_kind_e KIND = drop_kind(DROP);

    generate
        if (KIND == DROP_NONE) begin : g_none
            // Nothing discarded: the upper part is the whole sample.
            always_comb begin
                trunc_o  = wide_i;
                half_o   = 1'b0;
                sticky_o = 1'b0;
            end
        end else if (KIND == DROP_SINGLE) begin : g_single
            // One bit discarded: it is the half bit, nothing lies below it.
            always_comb begin
                trunc_o  = wide_i[IN_W-1:1];
                half_o   = wide_i[0];
                sticky_o = 1'b0;
            end
        end else begin : g_multi
            // Several bits discarded: upper slice equals an arithmetic shift.
            always_comb begin
                trunc_o  = wide_i[IN_W-1:DROP];
                half_o   = wide_i[DROP-1];
                sticky_o = |wide_i[DROP-2:0];
            end
        end
    endgenerate

endmodule

// File: rtl/cvg_round_incr.sv
// Decides the round-up increment (half-to-even) and applies it, either
// wrapping or clamping at the top of the signed output range.
// Assumes the truncated value already holds the sign; only positive
// overflow is possible because the increment is never negative.
module cvg_round_incr #(
    parameter int OUT_W    = 8,
    parameter bit SATURATE = 1'b0
) (
    input  logic [OUT_W-1:0] trunc_i,
    input  logic             half_i,
    input  logic             sticky_i,
    output logic [OUT_W-1:0] result_o
);
    localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

    logic bump;

    // Round up past the half point, or on an exact tie when odd.
    always_comb bump = half_i & (sticky_i | trunc_i[0]);

    generate
        if (SATURATE) begin : g_sat
            logic [OUT_W:0] sum_ext;
            logic           over;
            // Extended sum exposes a carry into the sign position.
            always_comb begin
                sum_ext  = {trunc_i[OUT_W-1], trunc_i} + {{OUT_W{1'b0}}, bump};
                over     = sum_ext[OUT_W] ^ sum_ext[OUT_W-1];
                result_o = over ? MAX_POS : sum_ext[OUT_W-1:0];
            end
        end else begin : g_wrap
            // Plain modulo addition at output width.
            always_comb result_o = trunc_i + {{(OUT_W-1){1'b0}}, bump};
        end
    endgenerate

endmodule

// File: rtl/cvg_round_outreg.sv
// Output stage: registers the qualifier every cycle and the data only on
// qualified cycles. Synchronous active-low reset clears both.
module cvg_round_outreg #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [OUT_W-1:0] dat_i,
    output logic             vld_o,
    output logic [OUT_W-1:0] dat_o
);
    // Capture a qualified result one cycle later; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            dat_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i)
                dat_o <= dat_i;
        end
    end

endmodule

// File: rtl/cvg_round_reducer.sv
// Top: reduces a signed IN_W-bit sample to OUT_W bits with
// round-half-to-even, one cycle of latency.
// Assumes IN_W >= OUT_W >= 2. SATURATE selects clamp instead of wrap.
module cvg_round_reducer #(
    parameter int IN_W     = 16,
    parameter int OUT_W    = 8,
    parameter bit SATURATE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    logic [OUT_W-1:0] trunc_w;
    logic             half_w;
    logic             sticky_w;
    logic [OUT_W-1:0] rounded_w;

    cvg_round_split #(
        .IN_W (IN_W),
        .OUT_W(OUT_W)
    ) u_split (
        .wide_i  (in_data),
        .trunc_o (trunc_w),
        .half_o  (half_w),
        .sticky_o(sticky_w)
    );

    cvg_round_incr #(
        .OUT_W   (OUT_W),
        .SATURATE(SATURATE)
    ) u_incr (
        .trunc_i (trunc_w),
        .half_i  (half_w),
        .sticky_i(sticky_w),
        .result_o(rounded_w)
    );

    cvg_round_outreg #(
        .OUT_W(OUT_W)
    ) u_outreg (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(in_valid),
        .dat_i(rounded_w),
        .vld_o(out_valid),
        .dat_o(out_data)
    );

endmodule

// File: rtl/cvg_round_reducer_chk.sv
// Checker bound to the reducer: relates port values across one clock.
// Assumes the same parameters as the bound instance.
module cvg_round_reducer_chk #(
    parameter int IN_W     = 16,
    parameter int OUT_W    = 8,
    parameter bit SATURATE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    localparam int               DROP    = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] ONE     = {{(OUT_W-1){1'b0}}, 1'b1};
    localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_data_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    generate
        if (DROP == 0) begin : g_pass
            assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_data == $past(in_data));
        end else if (DROP == 1) begin : g_one
            assert_single_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !(in_data[1] && in_data[0]))
                |=> out_data == $past(in_data[IN_W-1:1]));
        end else begin : g_multi
            assert_half_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_data[DROP-1])
                |=> out_data == $past(in_data[IN_W-1:DROP]));
            assert_above_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_data[DROP-1] && (|in_data[DROP-2:0])
                 && in_data[IN_W-1:DROP] != MAX_POS)
                |=> out_data == $past(in_data[IN_W-1:DROP]) + ONE);
            assert_even_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_data[DROP-1] && !(|in_data[DROP-2:0]) && !in_data[DROP])
                |=> out_data == $past(in_data[IN_W-1:DROP]));
        end

        if (SATURATE) begin : g_sat
            assert_no_sign_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_data[IN_W-1]) |=> !out_data[OUT_W-1]);
        end
    endgenerate

endmodule

bind cvg_round_reducer cvg_round_reducer_chk #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .SATURATE(SATURATE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/cvg_round_reducer_tb.sv
// Bench: vector table for the 16->8 wrapping instance, then directed tests
// for reset, hold, single-bit drop, equal width and saturation.
module cvg_round_reducer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] a_in = '0;
    logic [8:0]  b_in = '0;
    logic [7:0]  c_in = '0;
    logic [15:0] d_in = '0;
    logic        a_vo, b_vo, c_vo, d_vo;
    logic [7:0]  a_out, b_out, c_out, d_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cvg_round_reducer #(.IN_W(16), .OUT_W(8), .SATURATE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(a_in),
        .out_valid(a_vo), .out_data(a_out));
    cvg_round_reducer #(.IN_W(9), .OUT_W(8), .SATURATE(1'b0)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(b_in),
        .out_valid(b_vo), .out_data(b_out));
    cvg_round_reducer #(.IN_W(8), .OUT_W(8), .SATURATE(1'b0)) u_dut_eq (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(c_in),
        .out_valid(c_vo), .out_data(c_out));
    cvg_round_reducer #(.IN_W(16), .OUT_W(8), .SATURATE(1'b1)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(d_in),
        .out_valid(d_vo), .out_data(d_out));

    // {input, expected, requirement index} for the 16->8 wrapping instance
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 8'h00, 8'd3},
        {16'h1234, 8'h12, 8'd3},
        {16'h017F, 8'h01, 8'd3},
        {16'h0181, 8'h02, 8'd4},
        {16'h12C1, 8'h13, 8'd4},
        {16'h0080, 8'h00, 8'd5},
        {16'h0180, 8'h02, 8'd5},
        {16'h0280, 8'h02, 8'd5},
        {16'hFF80, 8'h00, 8'd6},
        {16'hFE80, 8'hFE, 8'd6},
        {16'hFD80, 8'hFE, 8'd6},
        {16'hFF7F, 8'hFF, 8'd6},
        {16'h7FFF, 8'h80, 8'd7},
        {16'h7F80, 8'h80, 8'd7}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one qualified sample to every instance, sample after the edge.
    task automatic step(input logic v, input logic [15:0] a, input logic [8:0] b,
                        input logic [7:0] c, input logic [15:0] d);
        @(negedge clk);
        vld = v; a_in = a; b_in = b; c_in = c; d_in = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid in reset", {7'd0, a_vo}, 8'h00);
        check("R10 data in reset", a_out, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][31:16], 9'h000, 8'h00, 16'h0000);
            check($sformatf("R%0d vec %0d", VEC[i][7:0], i), a_out, VEC[i][15:8]);
        end
        check("R9 valid one cycle later", {7'd0, a_vo}, 8'h01);

        // R2: single bit dropped
        step(1'b1, 16'h0000, 9'h003, 8'h00, 16'h0000);
        check("R2 1.5 -> 2", b_out, 8'h02);
        step(1'b1, 16'h0000, 9'h001, 8'h00, 16'h0000);
        check("R2 0.5 -> 0", b_out, 8'h00);
        step(1'b1, 16'h0000, 9'h1FF, 8'h00, 16'h0000);
        check("R2 R6 -0.5 -> 0", b_out, 8'h00);
        step(1'b1, 16'h0000, 9'h1FD, 8'h00, 16'h0000);
        check("R2 R6 -1.5 -> -2", b_out, 8'hFE);
        step(1'b1, 16'h0000, 9'h0FF, 8'h00, 16'h0000);
        check("R2 R7 127.5 wraps", b_out, 8'h80);

        // R1: equal widths
        step(1'b1, 16'h0000, 9'h000, 8'hA5, 16'h0000);
        check("R1 passthrough A5", c_out, 8'hA5);
        step(1'b1, 16'h0000, 9'h000, 8'h80, 16'h0000);
        check("R1 passthrough 80", c_out, 8'h80);

        // R8: saturation
        step(1'b1, 16'h0000, 9'h000, 8'h00, 16'h7FFF);
        check("R8 clamp 7FFF", d_out, 8'h7F);
        step(1'b1, 16'h0000, 9'h000, 8'h00, 16'h7F80);
        check("R8 clamp odd tie", d_out, 8'h7F);
        step(1'b1, 16'h0000, 9'h000, 8'h00, 16'h7E80);
        check("R8 R5 even tie no clamp", d_out, 8'h7E);
        step(1'b1, 16'h0000, 9'h000, 8'h00, 16'h8000);
        check("R8 most negative", d_out, 8'h80);

        // R9: hold when not qualified
        step(1'b1, 16'h0534, 9'h000, 8'h00, 16'h0000);
        check("R9 load", a_out, 8'h05);
        step(1'b0, 16'h3400, 9'h000, 8'h00, 16'h0000);
        check("R9 hold data", a_out, 8'h05);
        check("R9 valid low", {7'd0, a_vo}, 8'h00);

        // R10: reset mid-run
        step(1'b1, 16'h4000, 9'h000, 8'h00, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 valid cleared", {7'd0, a_vo}, 8'h00);
        check("R10 data cleared", a_out, 8'h00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule